// File: doc/BRIEF.md
# Single-Bit Sector Check-Code Corrector

This block decides what to do with one 512-byte sector after it has been read back. It takes the 24-bit check code that was stored next to the sector and the raw 32-bit parity word that the parity engine computed over the data just read. From these it works out whether the sector is clean, which single data bit must be flipped, whether the only damage is one flipped bit inside the stored code, or whether the sector cannot be repaired.

The raw parity word carries two 12-bit fields, with four unused bits above each one. The block compacts the two fields into a 24-bit code and inverts it, so that an erased sector reads as all ones and compares clean against all-ones storage. The same compacted code is emitted so that it can be written out as the stored code during a program operation.

The block is operated by a single-cycle start strobe. The results appear registered one cycle later, marked by a one-cycle done pulse, and they stay in place until the next strobe.

Top module: `sec_ecc_corrector`

## Requirements
- R1: The packed code is formed from raw bits 11..0, which become code bits 11..0, and raw bits 27..16, which become code bits 23..12. Raw bits 31..28 and 15..12 have no effect on any output.
- R2: The emitted packed code `packed_code_o` is the bitwise inverse of that packed value. A raw parity of zero yields 24'hFFFFFF, which checks clean against an all-ones stored code.
- R3: The syndrome is the XOR of the packed code and `stored_code_i`. A zero syndrome gives status 0 (none).
- R4: A syndrome counts as a correctable data error when its bits 23..12 are the exact bitwise complement of its bits 11..0. The result is status 1 (corrected), `byte_idx_o` equal to syndrome bits 23..15, and `bit_mask_o` equal to 1 shifted left by syndrome bits 14..12.
- R5: A correctable pattern whose byte index is not below the `SECTOR_BYTES` parameter gives status 3 (fail).
- R6: A syndrome with exactly one bit set gives status 2 (code-only error).
- R7: Every other nonzero syndrome gives status 3. Whenever the status is not 1, `byte_idx_o` and `bit_mask_o` are zero.
- R8: When `start_i` is high at a rising clock edge, `done_o` is high after that edge and all result outputs reflect the inputs sampled at that edge.
- R9: In a cycle without `start_i`, `done_o` is low after the next edge and every result output holds its value.
- R10: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to evaluate the inputs |
| stored_code_i | input | 24 | Check code read from storage |
| raw_parity_i | input | 32 | Raw parity word from the parity engine |
| done_o | output | 1 | One-cycle pulse marking fresh results |
| status_o | output | 2 | 0 none, 1 corrected, 2 code-only, 3 fail |
| byte_idx_o | output | 9 | Byte offset of the bit to flip |
| bit_mask_o | output | 8 | One-hot mask of the bit to flip within that byte |
| packed_code_o | output | 24 | Inverted packed code computed from raw_parity_i |

## Verification
The bench aims at the edges of the complement test.

- A syndrome that differs from a true complement in a single bit must be reported as fail. A design that tested only part of the halves would instead return a bogus correction.
- Single-bit syndromes at both ends of the code must come back as code-only. A design that checked the complement condition in the wrong order, or counted bits wrongly, would flip data.
- A second instance with a 300-byte limit is probed at byte 299 and at byte 300, where an off-by-one in the range test changes the status.
- Raw words that differ only in reserved bits must give identical results.
- Idle cycles must leave every output frozen, which catches a done signal that is level-held instead of pulsed.

// File: rtl/ecc1_pkg.sv
package ecc1_pkg;
  typedef enum logic [1:0] {
    ST_NONE  = 2'd0,
    ST_FIXED = 2'd1,
    ST_CODE  = 2'd2,
    ST_FAIL  = 2'd3
  } ecc_status_e;
endpackage

// File: rtl/ecc_code_pack.sv
module ecc_code_pack #(
  parameter int FIELD_W      = 12,
  parameter int FIELD_STRIDE = 16,
  parameter int NUM_FIELDS   = 2,
  localparam int RAW_W       = FIELD_STRIDE * NUM_FIELDS,
  localparam int CODE_W      = FIELD_W * NUM_FIELDS,
  localparam int RSV_W       = FIELD_STRIDE - FIELD_W
) (
  input  logic [RAW_W-1:0]  raw_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0]           packed_val;
  logic [RSV_W*NUM_FIELDS-1:0] rsv_bits;
  logic                        unused_rsv;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    assign packed_val[f*FIELD_W +: FIELD_W] = raw_i[f*FIELD_STRIDE +: FIELD_W];
    assign rsv_bits[f*RSV_W +: RSV_W]       = raw_i[f*FIELD_STRIDE+FIELD_W +: RSV_W];
  end

  // inverted so an erased (all-ones) stored code matches zero parity
  assign code_o     = ~packed_val;
  assign unused_rsv = ^rsv_bits;
endmodule

// File: rtl/ecc_syndrome_eval.sv
module ecc_syndrome_eval
  import ecc1_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int FIELD_W      = 12,
  parameter int BYTE_W       = 8,
  localparam int CODE_W      = 2 * FIELD_W,
  localparam int BITSEL_W    = $clog2(BYTE_W),
  localparam int IDX_W       = CODE_W - FIELD_W - BITSEL_W,
  localparam int LIM_W       = IDX_W + 1
) (
  input  logic [CODE_W-1:0] calc_i,
  input  logic [CODE_W-1:0] stored_i,
  output ecc_status_e       status_o,
  output logic [IDX_W-1:0]  byte_idx_o,
  output logic [BYTE_W-1:0] bit_mask_o
);
  logic [CODE_W-1:0]   syn;
  logic [FIELD_W-1:0]  syn_hi, syn_lo;
  logic [IDX_W-1:0]    idx;
  logic [BITSEL_W-1:0] bsel;
  logic                halves_comp, single_bit, in_range;

  assign syn         = calc_i ^ stored_i;
  assign syn_hi      = syn[CODE_W-1:FIELD_W];
  assign syn_lo      = syn[FIELD_W-1:0];
  assign halves_comp = &(syn_hi ^ syn_lo);
  assign single_bit  = (syn != '0) && ((syn & (syn - CODE_W'(1))) == '0);
  assign idx         = syn[CODE_W-1 -: IDX_W];
  assign bsel        = syn[FIELD_W +: BITSEL_W];
  assign in_range    = {1'b0, idx} < LIM_W'(SECTOR_BYTES);

  always_comb begin
    status_o   = ST_FAIL;
    byte_idx_o = '0;
    bit_mask_o = '0;
    if (syn == '0) begin
      status_o = ST_NONE;
    end else if (halves_comp) begin
      if (in_range) begin
        status_o   = ST_FIXED;
        byte_idx_o = idx;
        bit_mask_o = BYTE_W'(1) << bsel;
      end
    end else if (single_bit) begin
      status_o = ST_CODE;
    end
  end
endmodule

// File: rtl/sec_ecc_corrector.sv
module sec_ecc_corrector
  import ecc1_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [23:0] stored_code_i,
  input  logic [31:0] raw_parity_i,
  output logic        done_o,
  output logic [1:0]  status_o,
  output logic [8:0]  byte_idx_o,
  output logic [7:0]  bit_mask_o,
  output logic [23:0] packed_code_o
);
  localparam int FIELD_W = 12;
  localparam int STRIDE  = 16;
  localparam int BYTE_W  = 8;
  localparam int CODE_W  = 2 * FIELD_W;
  localparam int IDX_W   = CODE_W - FIELD_W - $clog2(BYTE_W);

  logic [CODE_W-1:0] calc_code;
  ecc_status_e       st_c;
  logic [IDX_W-1:0]  idx_c;
  logic [BYTE_W-1:0] mask_c;

  ecc_code_pack #(
    .FIELD_W     (FIELD_W),
    .FIELD_STRIDE(STRIDE),
    .NUM_FIELDS  (2)
  ) u_pack (
    .raw_i (raw_parity_i),
    .code_o(calc_code)
  );

  ecc_syndrome_eval #(
    .SECTOR_BYTES(SECTOR_BYTES),
    .FIELD_W     (FIELD_W),
    .BYTE_W      (BYTE_W)
  ) u_eval (
    .calc_i    (calc_code),
    .stored_i  (stored_code_i),
    .status_o  (st_c),
    .byte_idx_o(idx_c),
    .bit_mask_o(mask_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o        <= 1'b0;
      status_o      <= '0;
      byte_idx_o    <= '0;
      bit_mask_o    <= '0;
      packed_code_o <= '0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        status_o      <= st_c;
        byte_idx_o    <= idx_c;
        bit_mask_o    <= mask_c;
        packed_code_o <= calc_code;
      end
    end
  end
endmodule

// File: rtl/sec_ecc_corrector_chk.sv
module sec_ecc_corrector_chk #(
  parameter int SECTOR_BYTES = 512
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [23:0] stored_code_i,
  input logic        done_o,
  input logic [1:0]  status_o,
  input logic [8:0]  byte_idx_o,
  input logic [7:0]  bit_mask_o,
  input logic [23:0] packed_code_o
);
  assert_done_follows_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(status_o) && $stable(byte_idx_o) &&
                  $stable(bit_mask_o) && $stable(packed_code_o)));

  assert_clean_match_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 2'd0) |-> packed_code_o == $past(stored_code_i));

  assert_fix_halves_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 2'd1) |->
      ((&((packed_code_o[23:12] ^ $past(stored_code_i[23:12])) ^
          (packed_code_o[11:0]  ^ $past(stored_code_i[11:0])))) &&
       $countones(bit_mask_o) == 1));

  assert_fix_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 2'd1) |-> (32'(byte_idx_o) < SECTOR_BYTES));

  assert_code_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 2'd2) |->
      $countones(packed_code_o ^ $past(stored_code_i)) == 1);

  assert_no_flip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != 2'd1) |-> (byte_idx_o == '0 && bit_mask_o == '0));
endmodule

bind sec_ecc_corrector sec_ecc_corrector_chk #(.SECTOR_BYTES(SECTOR_BYTES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .stored_code_i(stored_code_i),
  .done_o       (done_o),
  .status_o     (status_o),
  .byte_idx_o   (byte_idx_o),
  .bit_mask_o   (bit_mask_o),
  .packed_code_o(packed_code_o)
);

// File: tb/sec_ecc_corrector_tb_top.sv
`timescale 1ns/1ps
module sec_ecc_corrector_tb_top;
  localparam int SMALL_SECTOR = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] stored = '0;
  logic [31:0] raw = '0;
  string       cur_req = "R10";

  logic        done_a, done_b;
  logic [1:0]  st_a, st_b;
  logic [8:0]  idx_a, idx_b;
  logic [7:0]  mask_a, mask_b;
  logic [23:0] code_a, code_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sec_ecc_corrector dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .stored_code_i(stored), .raw_parity_i(raw),
    .done_o(done_a), .status_o(st_a), .byte_idx_o(idx_a),
    .bit_mask_o(mask_a), .packed_code_o(code_a)
  );

  sec_ecc_corrector #(.SECTOR_BYTES(SMALL_SECTOR)) dut_small_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .stored_code_i(stored), .raw_parity_i(raw),
    .done_o(done_b), .status_o(st_b), .byte_idx_o(idx_b),
    .bit_mask_o(mask_b), .packed_code_o(code_b)
  );

  // behavioural reference: expected[k] for sector size k (0: 512, 1: 300)
  int unsigned e_done[2], e_st[2], e_idx[2], e_mask[2], e_code[2];

  function automatic int unsigned pack_ref(int unsigned r);
    int unsigned lo = r % 4096;
    int unsigned hi = (r / 65536) % 4096;
    return (~(hi * 4096 + lo)) & 32'hFFFFFF;
  endfunction

  task automatic classify(input int unsigned s, input int unsigned r, input int sect,
                          output int unsigned st, output int unsigned ix,
                          output int unsigned mk);
    int unsigned syn = pack_ref(r) ^ s;
    int unsigned hi = syn / 4096;
    int unsigned lo = syn % 4096;
    int ones = 0;
    for (int b = 0; b < 24; b++) if ((syn >> b) & 1) ones++;
    st = 3; ix = 0; mk = 0;
    if (syn == 0) st = 0;
    else if ((hi + lo) == 4095) begin
      if (int'(syn / 32768) < sect) begin
        st = 1; ix = syn / 32768; mk = 1 << (hi % 8);
      end
    end else if (ones == 1) st = 2;
  endtask

  always @(posedge clk or negedge rst_n) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        e_done[k] = 0; e_st[k] = 0; e_idx[k] = 0; e_mask[k] = 0; e_code[k] = 0;
      end else begin
        e_done[k] = start;
        if (start) begin
          classify(stored, raw, (k == 0) ? 512 : SMALL_SECTOR, e_st[k], e_idx[k], e_mask[k]);
          e_code[k] = pack_ref(raw);
        end
      end
    end
  end

  task automatic cmp(input int k, input int unsigned d, input int unsigned s,
                     input int unsigned ix, input int unsigned mk, input int unsigned c);
    n_cmp++;
    if (d != e_done[k] || s != e_st[k] || ix != e_idx[k] || mk != e_mask[k] || c != e_code[k]) begin
      n_bad++;
      $display("FAIL %s dut%0d: got done=%0d st=%0d idx=%0d mask=%h code=%h exp done=%0d st=%0d idx=%0d mask=%h code=%h",
               cur_req, k, d, s, ix, mk, c, e_done[k], e_st[k], e_idx[k], e_mask[k], e_code[k]);
    end
  endtask

  always @(posedge clk) begin
    #2;
    cmp(0, done_a, st_a, idx_a, mask_a, code_a);
    cmp(1, done_b, st_b, idx_b, mask_b, code_b);
  end

  task automatic fire(input string req, input int unsigned r, input int unsigned syn);
    @(negedge clk);
    cur_req = req;
    raw     = r;
    stored  = 24'(pack_ref(r) ^ syn);
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
  endtask

  function automatic int unsigned comp_syn(int unsigned hi);
    return (hi % 4096) * 4096 + ((~hi) % 4096);
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);           // R10 reset state compared each cycle
    rst_n = 1'b1;
    // R2: zero parity against erased storage
    @(negedge clk); cur_req = "R2"; raw = 0; stored = 24'hFFFFFF; start = 1;
    @(negedge clk); start = 0;
    fire("R3", 32'h0ABC_0123, 0);
    fire("R1", 32'hF5A5_F3C3, 0);       // reserved bits set
    fire("R1", 32'h05A5_03C3, 0);       // same fields, reserved clear
    fire("R4", 32'h0123_0456, comp_syn(12'h2A5));   // byte 84 bit 5
    fire("R4", 32'h0000_0FFF, comp_syn(12'hFFF));   // byte 511 bit 7 (fail on small)
    fire("R4", 32'h0777_0111, comp_syn(12'h000));   // byte 0 bit 0
    fire("R5", 32'h0321_0654, comp_syn(299 * 8 + 7)); // last valid on small
    fire("R5", 32'h0321_0654, comp_syn(300 * 8));     // first invalid on small
    fire("R5", 32'h0BAD_0F00, comp_syn(400 * 8 + 1));
    fire("R6", 32'h0135_0246, 24'h800000);
    fire("R6", 32'h0135_0246, 24'h000001);
    fire("R6", 32'h0135_0246, 24'h001000);
    fire("R7", 32'h0FED_0CBA, 24'h000003);
    fire("R7", 32'h0FED_0CBA, comp_syn(12'h2A5) ^ 24'h000001);
    fire("R7", 32'h0FED_0CBA, 24'hFFFFFF);
    cur_req = "R9";
    repeat (5) @(negedge clk);          // outputs must hold, done low
    fire("R8", 32'h0001_0002, comp_syn(12'h5A3));
    fire("R8", 32'h0002_0001, 0);       // back-to-back strobes
    for (int i = 0; i < 200; i++) begin
      int unsigned r = $urandom;
      int unsigned sel = $urandom % 4;
      int unsigned syn;
      case (sel)
        0: syn = 0;
        1: syn = comp_syn($urandom);
        2: syn = 1 << ($urandom % 24);
        default: syn = $urandom % 32'h1000000;
      endcase
      fire("R7", r, syn);
      if (i % 7 == 0) begin cur_req = "R9"; @(negedge clk); end
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule